// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Event Interrupts

The block controls a bank of 32 general-purpose pins through a 32-bit register interface with separate read and write strobes. Software sets, for each pin, whether the input sampler is on and whether the internal driver is on. It also sets the level to drive, an output inversion, and a pull-up. Storage-only words hold drive strength and alternate-function settings. Each pin's outside world appears as two inputs: a valid bit that says an external device is driving it, and the level that device drives.

Every clock the block works out each pin's level. An external driver comes first, then the internal driver, then the pull-up. The level, gated by the input enable, is stored as the sampled value. From that value the block keeps four sticky pending classes per pin: level high, level low, rising and falling. Each class is cleared by writing ones and has its own enable word. The enabled pending bits drive one interrupt line per pin. A per-pin flag shows when an external device and the internal driver are both active on the same pin.

Top module: `pin_bank`

## Requirements
- R1: With no external drive, a pin whose output enable is 1 shows level drive XOR invert on `pad_level`.
- R2: Priority of the pin level is fixed. When `ext_valid` is 1, `pad_level` equals `ext_data`. Otherwise, when output enable is 1, the driven value of R1 applies. Otherwise the pin takes its pull-up bit.
- R3: Each cycle the sampled bit (input enable AND `pad_level`) is stored. The value word (offset 0x00) reads back the bit stored at the edge that carries the read.
- R4: The high pending bit (0x2C) sets whenever the sampled bit is 1. The low pending bit (0x34) sets whenever it is 0. Both stay set until cleared.
- R5: The rising pending bit (0x1C) sets when the sampled bit is 1 and the stored bit is 0. The falling pending bit (0x24) sets on the opposite case. Both stay set until cleared.
- R6: A write to a pending word clears the bits written as 1 and keeps the bits written as 0. An event in the same cycle as the clear leaves its bit set.
- R7: `irq[i]` is 1 exactly when any pending class for pin i is set together with its enable bit. The enable words are rising 0x18, falling 0x20, high 0x28 and low 0x30.
- R8: Reset (synchronous, active high) clears every register. After reset all readable words return zero.
- R9: `short_flag[i]` is 1 exactly when `ext_valid[i]` and the output enable of pin i are both 1.
- R10: Reads of unmapped or misaligned addresses (beyond 0x40, or low two bits non-zero) return zero, and writes to them change nothing. Writes to the value word are also ignored.
- R11: Read data appears on `bus_rdata` the cycle after `bus_rd`. The words at these offsets read back as last written: input enable 0x04, output enable 0x08, drive 0x0C, pull-up 0x10, strength 0x14, alternate enable 0x38, alternate select 0x3C, invert 0x40. Bus data bit i belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| ext_valid | input | 32 | Per pin: an external device is driving |
| ext_data | input | 32 | Per pin: level driven by the external device |
| pad_level | output | 32 | Resolved level of each pin |
| short_flag | output | 32 | Per pin: both external and internal drivers active |
| irq | output | 32 | Per-pin interrupt line |

## Verification
The hardest case to reach is a clear and a new event landing on the same pending bit in the same cycle. The bench keeps a pin's sampled level high and then writes all ones to the high pending word. The bit must still read back as set. Edges are produced by toggling `ext_data` on externally driven pins, and by flipping the invert word on internally driven pins while their inputs are enabled. Each rising and falling edge is then seen as a single-cycle transition against the stored value.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    localparam int unsigned GP_W    = 32;
    localparam int unsigned LAST_IX = 16;

    typedef enum logic [4:0] {
        RG_VALUE, RG_IN_EN, RG_OUT_EN, RG_DRIVE, RG_PULL, RG_STRENGTH,
        RG_RISE_EN, RG_RISE_PEND, RG_FALL_EN, RG_FALL_PEND,
        RG_HI_EN, RG_HI_PEND, RG_LO_EN, RG_LO_PEND,
        RG_ALT_EN, RG_ALT_SEL, RG_INVERT, RG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [GP_W-1:0] in_en;
        logic [GP_W-1:0] out_en;
        logic [GP_W-1:0] drive;
        logic [GP_W-1:0] pull;
        logic [GP_W-1:0] strength;
        logic [GP_W-1:0] alt_en;
        logic [GP_W-1:0] alt_sel;
        logic [GP_W-1:0] invert;
        logic [GP_W-1:0] rise_en;
        logic [GP_W-1:0] fall_en;
        logic [GP_W-1:0] hi_en;
        logic [GP_W-1:0] lo_en;
    } ctrl_t;

    typedef struct packed {
        logic [GP_W-1:0] rise;
        logic [GP_W-1:0] fall;
        logic [GP_W-1:0] hi;
        logic [GP_W-1:0] lo;
    } pend_t;

    function automatic reg_sel_e decode_word(input logic aligned, input int unsigned idx);
        if (!aligned || idx > LAST_IX) return RG_NONE;
        return reg_sel_e'(idx[4:0]);
    endfunction

endpackage

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
    import pin_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  reg_sel_e        sel,
    input  logic [GP_W-1:0] wdata,
    output ctrl_t           ctrl,
    output pend_t           clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            case (sel)
                RG_IN_EN:    ctrl.in_en    <= wdata;
                RG_OUT_EN:   ctrl.out_en   <= wdata;
                RG_DRIVE:    ctrl.drive    <= wdata;
                RG_PULL:     ctrl.pull     <= wdata;
                RG_STRENGTH: ctrl.strength <= wdata;
                RG_RISE_EN:  ctrl.rise_en  <= wdata;
                RG_FALL_EN:  ctrl.fall_en  <= wdata;
                RG_HI_EN:    ctrl.hi_en    <= wdata;
                RG_LO_EN:    ctrl.lo_en    <= wdata;
                RG_ALT_EN:   ctrl.alt_en   <= wdata;
                RG_ALT_SEL:  ctrl.alt_sel  <= wdata;
                RG_INVERT:   ctrl.invert   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (wr) begin
            case (sel)
                RG_RISE_PEND: clr.rise = wdata;
                RG_FALL_PEND: clr.fall = wdata;
                RG_HI_PEND:   clr.hi   = wdata;
                RG_LO_PEND:   clr.lo   = wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pin_bank_resolve.sv
module pin_bank_resolve
    import pin_bank_pkg::*;
(
    input  logic [GP_W-1:0] in_en,
    input  logic [GP_W-1:0] out_en,
    input  logic [GP_W-1:0] drive,
    input  logic [GP_W-1:0] invert,
    input  logic [GP_W-1:0] pull,
    input  logic [GP_W-1:0] ext_valid,
    input  logic [GP_W-1:0] ext_data,
    output logic [GP_W-1:0] pad,
    output logic [GP_W-1:0] sample,
    output logic [GP_W-1:0] short_flag
);

    for (genvar i = 0; i < GP_W; i++) begin : g_pin
        logic own_level;
        assign own_level     = out_en[i] & (drive[i] ^ invert[i]);
        assign pad[i]        = ext_valid[i] ? ext_data[i]
                             : (out_en[i] ? own_level : pull[i]);
        assign sample[i]     = in_en[i] & pad[i];
        assign short_flag[i] = ext_valid[i] & out_en[i];
    end

    always_comb begin
        AST_EXT_WINS: assert (((pad ^ ext_data) & ext_valid) == '0); // R2
    end

endmodule

// File: rtl/pin_bank_events.sv
module pin_bank_events
    import pin_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [GP_W-1:0] sample,
    input  pend_t           clr,
    input  pend_t           en,
    output logic [GP_W-1:0] value_q,
    output pend_t           pend,
    output logic [GP_W-1:0] irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            pend    <= '0;
        end else begin
            value_q   <= sample;
            pend.hi   <= (pend.hi   & ~clr.hi)   | sample;
            pend.lo   <= (pend.lo   & ~clr.lo)   | ~sample;
            pend.rise <= (pend.rise & ~clr.rise) | (sample & ~value_q);
            pend.fall <= (pend.fall & ~clr.fall) | (~sample & value_q);
        end
    end

    assign irq = (pend.hi & en.hi) | (pend.lo & en.lo)
               | (pend.rise & en.rise) | (pend.fall & en.fall);

    AST_HI_STICKY: assert property (@(posedge clk) disable iff (rst)
        (clr.hi == '0) |=> ((pend.hi & $past(pend.hi)) == $past(pend.hi))); // R4

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend.rise & ~$past(pend.rise) & ~$past(sample & ~value_q)) == '0)); // R5

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(sample)) & ~pend.hi) == '0)); // R6

endmodule

// File: rtl/pin_bank.sv
module pin_bank
    import pin_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [GP_W-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [GP_W-1:0]   bus_rdata,
    input  logic [GP_W-1:0]   ext_valid,
    input  logic [GP_W-1:0]   ext_data,
    output logic [GP_W-1:0]   pad_level,
    output logic [GP_W-1:0]   short_flag,
    output logic [GP_W-1:0]   irq
);

    reg_sel_e        sel;
    ctrl_t           ctrl;
    pend_t           clr;
    pend_t           pend;
    pend_t           en;
    logic [GP_W-1:0] sample;
    logic [GP_W-1:0] value_q;

    assign sel = decode_word(bus_addr[1:0] == 2'b00, int'(bus_addr[ADDR_W-1:2]));

    pin_bank_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .ctrl  (ctrl),
        .clr   (clr)
    );

    pin_bank_resolve u_resolve (
        .in_en      (ctrl.in_en),
        .out_en     (ctrl.out_en),
        .drive      (ctrl.drive),
        .invert     (ctrl.invert),
        .pull       (ctrl.pull),
        .ext_valid  (ext_valid),
        .ext_data   (ext_data),
        .pad        (pad_level),
        .sample     (sample),
        .short_flag (short_flag)
    );

    assign en.rise = ctrl.rise_en;
    assign en.fall = ctrl.fall_en;
    assign en.hi   = ctrl.hi_en;
    assign en.lo   = ctrl.lo_en;

    pin_bank_events u_events (
        .clk     (clk),
        .rst     (rst),
        .sample  (sample),
        .clr     (clr),
        .en      (en),
        .value_q (value_q),
        .pend    (pend),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                RG_VALUE:     bus_rdata <= value_q;
                RG_IN_EN:     bus_rdata <= ctrl.in_en;
                RG_OUT_EN:    bus_rdata <= ctrl.out_en;
                RG_DRIVE:     bus_rdata <= ctrl.drive;
                RG_PULL:      bus_rdata <= ctrl.pull;
                RG_STRENGTH:  bus_rdata <= ctrl.strength;
                RG_RISE_EN:   bus_rdata <= ctrl.rise_en;
                RG_RISE_PEND: bus_rdata <= pend.rise;
                RG_FALL_EN:   bus_rdata <= ctrl.fall_en;
                RG_FALL_PEND: bus_rdata <= pend.fall;
                RG_HI_EN:     bus_rdata <= ctrl.hi_en;
                RG_HI_PEND:   bus_rdata <= pend.hi;
                RG_LO_EN:     bus_rdata <= ctrl.lo_en;
                RG_LO_PEND:   bus_rdata <= pend.lo;
                RG_ALT_EN:    bus_rdata <= ctrl.alt_en;
                RG_ALT_SEL:   bus_rdata <= ctrl.alt_sel;
                RG_INVERT:    bus_rdata <= ctrl.invert;
                default:      bus_rdata <= '0;
            endcase
        end
    end

    AST_VALUE_TRACKS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (value_q == $past(ctrl.in_en & pad_level))); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == RG_NONE) |=> (bus_rdata == '0)); // R10

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~(pend.hi | pend.lo | pend.rise | pend.fall)) == '0)); // R7

    AST_SHORT_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        ((short_flag & ~ext_valid) == '0)); // R9

endmodule

// File: tb/pin_bank_test.sv
module pin_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [31:0] ext_valid;
    logic [31:0] ext_data;
    logic [31:0] pad_level;
    logic [31:0] short_flag;
    logic [31:0] irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pin_bank uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .ext_valid  (ext_valid),
        .ext_data   (ext_data),
        .pad_level  (pad_level),
        .short_flag (short_flag),
        .irq        (irq)
    );

    // Reference model: one word per register, indexed by word number.
    logic [31:0] m_reg [0:16];
    logic [31:0] exp_rd;
    logic        rd_due = 1'b0;
    string       rd_tag = "R11";

    function automatic logic [31:0] m_pad();
        logic [31:0] r;
        for (int b = 0; b < 32; b++) begin
            if (ext_valid[b])        r[b] = ext_data[b];
            else if (m_reg[2][b])    r[b] = m_reg[3][b] ^ m_reg[16][b];
            else                     r[b] = m_reg[4][b];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_irq();
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) begin
            if ((m_reg[7][b] && m_reg[6][b]) || (m_reg[9][b] && m_reg[8][b]) ||
                (m_reg[11][b] && m_reg[10][b]) || (m_reg[13][b] && m_reg[12][b]))
                r[b] = 1'b1;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        logic [31:0] s;
        logic [31:0] prev;
        int idx;
        idx = int'(bus_addr) / 4;
        rd_due = bus_rd;
        if (rst) begin
            for (int k = 0; k <= 16; k++) m_reg[k] = '0;
            exp_rd = '0;
        end else begin
            if (bus_rd)
                exp_rd = (bus_addr[1:0] == 0 && idx <= 16) ? m_reg[idx] : 32'h0;
            s    = m_reg[1] & m_pad();
            prev = m_reg[0];
            for (int b = 0; b < 32; b++) begin
                logic clr_it;
                clr_it = 1'b0;
                if (s[b])                  m_reg[11][b] = 1'b1;
                else if (bus_wr && bus_addr == 8'h2C && bus_wdata[b]) m_reg[11][b] = 1'b0;
                if (!s[b])                 m_reg[13][b] = 1'b1;
                else if (bus_wr && bus_addr == 8'h34 && bus_wdata[b]) m_reg[13][b] = 1'b0;
                if (s[b] && !prev[b])      m_reg[7][b] = 1'b1;
                else if (bus_wr && bus_addr == 8'h1C && bus_wdata[b]) m_reg[7][b] = 1'b0;
                if (!s[b] && prev[b])      m_reg[9][b] = 1'b1;
                else if (bus_wr && bus_addr == 8'h24 && bus_wdata[b]) m_reg[9][b] = 1'b0;
                if (clr_it) m_reg[0][b] = 1'b0;
            end
            m_reg[0] = s;
            if (bus_wr && bus_addr[1:0] == 0 && idx >= 1 && idx <= 16 &&
                idx != 7 && idx != 9 && idx != 11 && idx != 13)
                m_reg[idx] = bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #5;
        chk("R2 pad_level", pad_level, m_pad());
        chk("R9 short_flag", short_flag, ext_valid & m_reg[2]);
        chk("R7 irq", irq, m_irq());
        if (rd_due) chk(rd_tag, bus_rdata, exp_rd);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1; rd_tag = tag;
        cyc();
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        ext_valid = '0; ext_data = '0;
        repeat (3) cyc();
        rst = 1'b0;
        // R8: all readable words zero straight after reset
        rd(8'h04, "R8 in_en"); rd(8'h08, "R8 out_en"); rd(8'h1C, "R8 rise_pend");
        rd(8'h40, "R8 invert");
        // R4: low pending sets from the idle zero sample
        rd(8'h34, "R4 lo_pend");
        // R1 / R2: pull-ups, then internal drive with invert
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_FFFF);
        cyc();
        rd(8'h00, "R3 value");
        rd(8'h2C, "R4 hi_pend");
        wr(8'h0C, 32'h0F0F_0F0F);
        wr(8'h40, 32'h0000_00F0);
        wr(8'h08, 32'h00FF_00FF);
        cyc(); // R1 pad compared
        rd(8'h00, "R1 value");
        // R2 / R9: external drive overrides, overlaps with out_en
        ext_valid = 32'h8000_00FF; ext_data = 32'h8000_00AA;
        cyc();
        rd(8'h00, "R2 value");
        // R7: enable every class, then generate edges
        wr(8'h1C, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h1C, "R6 rise_pend after clear");
        wr(8'h18, 32'h0000_000F);
        ext_data = 32'h0000_0055; // R5 bits 0,2 rise, bits 1,3 fall
        cyc();
        rd(8'h1C, "R5 rise_pend");
        rd(8'h24, "R5 fall_pend");
        wr(8'h20, 32'h0000_00F0);
        wr(8'h28, 32'h0000_0100);
        wr(8'h30, 32'h0100_0000);
        wr(8'h40, 32'h00FF_0000); // internal invert flips upper byte edges
        cyc(); cyc();
        rd(8'h24, "R5 fall_pend");
        // R6: partial clear keeps zero bits; same-cycle event wins
        wr(8'h1C, 32'h0000_0001);
        rd(8'h1C, "R6 rise_pend partial");
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, "R6 hi_pend event wins");
        wr(8'h34, 32'h0000_FF00);
        rd(8'h34, "R6 lo_pend");
        // R10: unmapped, misaligned and value writes ignored
        wr(8'h44, 32'hDEAD_BEEF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1234_5678);
        rd(8'h44, "R10 unmapped");
        rd(8'h05, "R10 misaligned");
        rd(8'hFC, "R10 high offset");
        rd(8'h04, "R10 in_en unchanged");
        rd(8'h00, "R10 value not written");
        // R11: storage-only words read back
        wr(8'h14, 32'hA5A5_0003);
        wr(8'h38, 32'h0000_FFF0);
        wr(8'h3C, 32'h1357_9BDF);
        rd(8'h14, "R11 strength");
        rd(8'h38, "R11 alt_en");
        rd(8'h3C, "R11 alt_sel");
        rd(8'h0C, "R11 drive");
        // R3: toggle inputs for a stretch and track the value word
        for (int n = 0; n < 40; n++) begin
            ext_valid = 32'hFFFF_0000 ^ (32'h1 << (n % 32));
            ext_data  = 32'h9E37_79B9 * (n + 1);
            if (n % 4 == 0) wr(8'h2C, 32'hFFFF_FFFF);
            else if (n % 4 == 1) wr(8'h24, 32'h00FF_00FF);
            else rd(8'h00, "R3 value stream");
        end
        // R8: reset in the middle clears everything again
        rst = 1'b1; cyc(); rst = 1'b0;
        rd(8'h24, "R8 fall_pend after reset");
        rd(8'h3C, "R8 alt_sel after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule